// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates eight level-sensitive hardware interrupt lines for a processor core. Each line is sampled into a pending field every cycle, qualified by a per-source enable mask and by a global enable, and the most urgent surviving source is presented to the core as a request together with its index. Bit 7 is the most urgent source and bit 0 the least urgent.

When the core accepts a request with the entry strobe, the block pushes the current mask onto an internal last-in-first-out store. It then narrows the live mask to the sources strictly more urgent than the accepted one and leaves the global enable set, so only those sources can nest on top. It also records a fixed external-interrupt exception code. The return strobe clears the global enable and pops the most recently saved mask. Software reads and writes a status word and a cause word through a simple register port. Program-counter saving, pipeline flushing and the handler itself are handled elsewhere.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, the status word and cause word both read 0, and `irq_req` is 0.
- R2: Cause bits 15:8 show `irq_lines` as sampled at the previous clock edge. A software write to those bits has no effect.
- R3: `irq_req` is 1 exactly when the global enable (status bit 0) is 1, the AND of pending bits and mask bits (status 15:8) is nonzero, and fewer than STACK_DEPTH masks are saved.
- R4: `irq_id` is the index of the highest set bit of the pending-AND-mask candidate set. Bit 7 is the most urgent.
- R5: An entry strobe while `irq_req` is 1 saves the mask. The new mask keeps only bits above `irq_id`. The global enable stays 1, and cause bits 6:2 take EXC_EXT_CODE (default 0).
- R6: A return strobe clears the global enable and restores the most recently saved mask. If no mask is saved, the mask keeps its value.
- R7: Saved masks come back in LIFO order for up to STACK_DEPTH (8) nested entries. While the store is full, `irq_req` stays 0.
- R8: An entry strobe while `irq_req` is 0 changes neither the mask nor the exception code, and saves nothing.
- R9: If a return strobe and an entry strobe arrive in the same cycle, only the return takes effect. A software write in the same cycle as an accepted entry or a return is discarded.
- R10: With `reg_sel`=0 (status), software writes mask 15:8, user-mode bit 4, exception-level bit 1 and global enable bit 0. With `reg_sel`=1 (cause), it writes branch-delay bit 31 and exception code 6:2. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines | input | 8 | Level-sensitive interrupt sources, bit 7 most urgent |
| reg_sel | input | 1 | Register select: 0 status, 1 cause |
| reg_we | input | 1 | Software write strobe |
| reg_wdata | input | 32 | Software write data |
| reg_rdata | output | 32 | Read data of the selected register |
| take_irq | input | 1 | Entry strobe from the core |
| irq_return | input | 1 | Return strobe from the core |
| irq_req | output | 1 | Interrupt request to the core |
| irq_id | output | 3 | Index of the selected source |

## Verification
Three pairs of actions can land in the same cycle: an accepted entry and a software status write, a return and a software write, and a return and an entry. The bench drives each pair together on one edge. It then reads the status word and judges whether the mask matches the hardware action alone. For the return-with-entry case, a follow-up return on a now-empty store must leave the mask unchanged, which proves nothing was pushed. The priority and masking logic is swept over all 256 pending patterns against three mask families, and the expected winner is computed arithmetically.

// File: rtl/irq_nest_pkg.sv
`timescale 1ns/1ps
package irq_nest_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned NSRC       = 8;
  localparam int unsigned ST_IE      = 0;
  localparam int unsigned ST_EXL     = 1;
  localparam int unsigned ST_UM      = 4;
  localparam int unsigned FLD_LO     = 8;
  localparam int unsigned CA_EXC_LO  = 2;
  localparam int unsigned CA_EXC_W   = 5;
  localparam int unsigned CA_BD      = 31;
  typedef enum logic {SEL_STATUS = 1'b0, SEL_CAUSE = 1'b1} reg_sel_e;
endpackage

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |cand;
    idx = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (cand[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_mask_stack.sv
`timescale 1ns/1ps
module irq_mask_stack #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  always_comb begin
    cnt_d = cnt_q;
    if (push && !full)       cnt_d = cnt_q + 1'b1;
    else if (pop && !empty)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_slot
    logic slot_we;
    assign slot_we = push && !full && (cnt_q == CW'(g));
    always_ff @(posedge clk) begin
      if (slot_we) mem[g] <= din;
    end
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (cnt_q == CW'(i + 1)) dout = mem[i];
    end
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  a_r6_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
  a_r9_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n) !(push && pop));
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/irq_nest_ctrl.sv
`timescale 1ns/1ps
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int unsigned STACK_DEPTH  = 8,
  parameter logic [4:0]  EXC_EXT_CODE = 5'd0,
  localparam int unsigned IW = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_lines,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              take_irq,
  input  logic              irq_return,
  output logic              irq_req,
  output logic [IW-1:0]     irq_id
);
  // reset: asynchronous assert, synchronous release
  logic rst_m_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_n <= rst_m_q;
    end
  end

  logic [NSRC-1:0] pend_q, mask_q, mask_d;
  logic            ie_q, ie_d, exl_q, exl_d, um_q, um_d, bd_q, bd_d;
  logic [CA_EXC_W-1:0] exc_q, exc_d;

  logic [NSRC-1:0] cand;
  logic            cand_any, stk_empty, stk_full;
  logic [NSRC-1:0] stk_top;
  logic            accept, pop_en, sw_wr;

  function automatic logic [NSRC-1:0] keep_above(input logic [IW-1:0] k);
    logic [NSRC-1:0] r;
    for (int i = 0; i < int'(NSRC); i++) r[i] = (i > int'(k));
    return r;
  endfunction

  assign cand = pend_q & mask_q;

  irq_prio_enc #(.N(NSRC)) u_enc (
    .cand (cand),
    .any  (cand_any),
    .idx  (irq_id)
  );

  assign irq_req = ie_q && cand_any && !stk_full;
  assign accept  = take_irq && irq_req && !irq_return;
  assign pop_en  = irq_return && !stk_empty;
  assign sw_wr   = reg_we && !accept && !irq_return;

  irq_mask_stack #(.W(NSRC), .DEPTH(STACK_DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_s_n),
    .push  (accept),
    .pop   (pop_en),
    .din   (mask_q),
    .dout  (stk_top),
    .empty (stk_empty),
    .full  (stk_full)
  );

  // next state
  always_comb begin
    mask_d = mask_q;
    ie_d   = ie_q;
    exl_d  = exl_q;
    um_d   = um_q;
    bd_d   = bd_q;
    exc_d  = exc_q;
    if (irq_return) begin
      ie_d = 1'b0;
      if (!stk_empty) mask_d = stk_top;
    end else if (accept) begin
      mask_d = mask_q & keep_above(irq_id);
      ie_d   = 1'b1;
      exc_d  = EXC_EXT_CODE;
    end else if (sw_wr) begin
      if (reg_sel == SEL_STATUS) begin
        mask_d = reg_wdata[FLD_LO +: NSRC];
        um_d   = reg_wdata[ST_UM];
        exl_d  = reg_wdata[ST_EXL];
        ie_d   = reg_wdata[ST_IE];
      end else begin
        bd_d  = reg_wdata[CA_BD];
        exc_d = reg_wdata[CA_EXC_LO +: CA_EXC_W];
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pend_q <= '0;
      mask_q <= '0;
      ie_q   <= 1'b0;
      exl_q  <= 1'b0;
      um_q   <= 1'b0;
      bd_q   <= 1'b0;
      exc_q  <= '0;
    end else begin
      pend_q <= irq_lines;
      mask_q <= mask_d;
      ie_q   <= ie_d;
      exl_q  <= exl_d;
      um_q   <= um_d;
      bd_q   <= bd_d;
      exc_q  <= exc_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_STATUS) begin
      reg_rdata[FLD_LO +: NSRC] = mask_q;
      reg_rdata[ST_UM]          = um_q;
      reg_rdata[ST_EXL]         = exl_q;
      reg_rdata[ST_IE]          = ie_q;
    end else begin
      reg_rdata[FLD_LO +: NSRC]         = pend_q;
      reg_rdata[CA_BD]                  = bd_q;
      reg_rdata[CA_EXC_LO +: CA_EXC_W]  = exc_q;
    end
  end

  a_r2_pend_tracks: assert property (@(posedge clk) disable iff (!rst_s_n)
    1'b1 |=> pend_q == $past(irq_lines));
  a_r4_top_winner: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_req |-> ((cand >> irq_id) == NSRC'(1)));
  a_r5_entry_narrows: assert property (@(posedge clk) disable iff (!rst_s_n)
    accept |=> ((mask_q & ~keep_above($past(irq_id))) == '0) && ie_q);
  a_r6_return_clears_ie: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_return |=> !ie_q);
  a_r6_return_restores: assert property (@(posedge clk) disable iff (!rst_s_n)
    pop_en |=> mask_q == $past(stk_top));
  a_r8_no_req_no_change: assert property (@(posedge clk) disable iff (!rst_s_n)
    (take_irq && !irq_req && !irq_return && !reg_we) |=> $stable(mask_q) && $stable(exc_q));
endmodule

// File: tb/irq_nest_ctrl_bench.sv
`timescale 1ns/1ps
module irq_nest_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  irq_lines;
  logic        reg_sel, reg_we, take_irq, irq_return;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq_req;
  logic [2:0]  irq_id;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_nest_ctrl u_irq_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_sel(reg_sel),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .take_irq(take_irq), .irq_return(irq_return), .irq_req(irq_req), .irq_id(irq_id)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    reg_sel = sel; #0.5; d = reg_rdata;
  endtask

  task automatic strobe(input logic t, input logic r);
    take_irq = t; irq_return = r;
    tick();
    take_irq = 1'b0; irq_return = 1'b0;
  endtask

  function automatic int top_bit(input logic [7:0] x);
    int r = -1;
    for (int i = 0; i < 8; i++) if (x[i]) r = i;
    return r;
  endfunction

  function automatic logic [7:0] above(input int k);
    return 8'(8'hFF << (k + 1));
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; irq_lines = 8'h00; reg_sel = 1'b0; reg_we = 1'b0;
    reg_wdata = '0; take_irq = 1'b0; irq_return = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    rd(1'b0, v); chk("R1 status", v, 32'h0);
    rd(1'b1, v); chk("R1 cause", v, 32'h0);
    chk("R1 req", {31'b0, irq_req}, 32'h0);

    // R10 writable fields
    wr(1'b0, 32'hFFFF_FFFF); rd(1'b0, v); chk("R10 status fields", v, 32'h0000_FF13);
    wr(1'b1, 32'hFFFF_FFFF); rd(1'b1, v); chk("R10 cause fields", v, 32'h8000_007C);
    wr(1'b1, 32'h0); wr(1'b0, 32'h0);

    // R2 pending sampled, read-only
    irq_lines = 8'hA5; tick();
    rd(1'b1, v); chk("R2 pending sampled", v, 32'h0000_A500);
    wr(1'b1, 32'h0000_5A00); rd(1'b1, v); chk("R2 pending write ignored", v, 32'h0000_A500);

    // R3/R4 sweep
    for (int ms = 0; ms < 3; ms++) begin
      for (int p = 0; p < 256; p++) begin
        logic [7:0] m;
        int hb;
        m = (ms == 0) ? 8'hFF : (ms == 1) ? 8'h5A : (8'(p) ^ 8'h3C);
        wr(1'b0, {16'h0, m, 8'h01});
        irq_lines = 8'(p); tick();
        hb = top_bit(8'(p) & m);
        chk("R3 request", {31'b0, irq_req}, {31'b0, hb >= 0});
        if (hb >= 0) chk("R4 winner", {29'b0, irq_id}, 32'(hb));
      end
    end
    wr(1'b0, 32'h0000_FF00); irq_lines = 8'hFF; tick();
    chk("R3 global enable off", {31'b0, irq_req}, 32'h0);

    // R5 entry and R6 return
    wr(1'b1, 32'h0000_007C);
    wr(1'b0, 32'h0000_FF01);
    irq_lines = 8'h24; tick();
    chk("R4 id5", {29'b0, irq_id}, 32'd5);
    strobe(1'b1, 1'b0);
    rd(1'b0, v); chk("R5 mask narrowed", v, 32'h0000_C001);
    rd(1'b1, v); chk("R5 exception code", v, 32'h0000_2400);
    irq_lines = 8'h80; tick();
    chk("R5 nested request", {31'b0, irq_req}, 32'h1);
    strobe(1'b1, 1'b0);
    rd(1'b0, v); chk("R5 second entry", v, 32'h0000_0001);
    strobe(1'b0, 1'b1);
    rd(1'b0, v); chk("R6 restore C0", v, 32'h0000_C000);
    wr(1'b0, 32'h0000_C001);
    strobe(1'b0, 1'b1);
    rd(1'b0, v); chk("R6 restore FF", v, 32'h0000_FF00);
    strobe(1'b0, 1'b1);
    rd(1'b0, v); chk("R6 empty return", v, 32'h0000_FF00);

    // R8 entry without request
    wr(1'b1, 32'h0000_0040);
    irq_lines = 8'h01; tick();
    chk("R8 no request", {31'b0, irq_req}, 32'h0);
    strobe(1'b1, 1'b0);
    rd(1'b0, v); chk("R8 mask kept", v, 32'h0000_FF00);
    rd(1'b1, v); chk("R8 code kept", v, 32'h0000_0140);
    strobe(1'b0, 1'b1);
    rd(1'b0, v); chk("R8 nothing saved", v, 32'h0000_FF00);

    // R9 conflicts
    wr(1'b0, 32'h0000_FF01);
    irq_lines = 8'h10; tick();
    take_irq = 1'b1; reg_sel = 1'b0; reg_we = 1'b1; reg_wdata = 32'h0000_0001;
    tick();
    take_irq = 1'b0; reg_we = 1'b0;
    rd(1'b0, v); chk("R9 entry beats write", v, 32'h0000_E001);
    irq_lines = 8'h80; tick();
    strobe(1'b1, 1'b1);
    rd(1'b0, v); chk("R9 return beats entry", v, 32'h0000_FF00);
    strobe(1'b0, 1'b1);
    rd(1'b0, v); chk("R9 no push on conflict", v, 32'h0000_FF00);
    irq_return = 1'b1; reg_sel = 1'b0; reg_we = 1'b1; reg_wdata = 32'h0000_0F01;
    tick();
    irq_return = 1'b0; reg_we = 1'b0;
    rd(1'b0, v); chk("R9 return beats write", v, 32'h0000_FF00);

    // R7 eight-deep nesting
    wr(1'b0, 32'h0000_FF01);
    for (int i = 0; i < 8; i++) begin
      irq_lines = 8'(1 << i); tick();
      chk("R7 nest request", {31'b0, irq_req}, 32'h1);
      strobe(1'b1, 1'b0);
      rd(1'b0, v); chk("R7 nest mask", v, {16'h0, above(i), 8'h01});
    end
    wr(1'b0, 32'h0000_FF01);
    irq_lines = 8'hFF; tick();
    chk("R7 full blocks request", {31'b0, irq_req}, 32'h0);
    for (int k = 0; k < 8; k++) begin
      strobe(1'b0, 1'b1);
      rd(1'b0, v); chk("R7 LIFO restore", v, {16'h0, 8'(8'hFF << (7 - k)), 8'h00});
    end
    wr(1'b0, 32'h0000_FF01); tick();
    chk("R7 request after unwind", {31'b0, irq_req}, 32'h1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule